// File: doc/BRIEF.md
# Destructive-Read Magnetic Bit Cycle Sequencer

This block times one access to a bistable magnetic storage element, for example a flip-dot pixel used as a one-bit core. Reading such an element destroys its content: the read pulse forces the element toward 0, and a comparator shows whether it flipped. Every access therefore runs the same fixed sequence. First the read side is precharged and pulsed, and the sensed bit is latched. Then the write side is precharged and a pulse of the chosen polarity puts a value back into the element.

A host raises an access request together with a read/write select and a data bit. The block raises busy and runs the sequence. On a read it writes the sensed bit back. On a write it stores the data bit instead. The latched sensed bit appears on data out. Seven independent select lines pick the storage unit, one line per unit, so that several boards can be chained with continuous addressing. The block gates every drive enable with that selection.

Top module: `core_access_seq`

## Requirements
- R1: An active-low synchronous reset leaves busy low, data out 0 and every precharge and drive enable low.
- R2: When access is sampled high at a clock edge while the block is idle, busy is high from that edge. It stays high for exactly 11 cycles and is then low again.
- R3: Counting busy cycles from 0, the phases run in this order with these lengths: read precharge (cycles 0-1, precharge enable), read pulse (cycles 2-4, drive-to-0 enable), latch (cycle 5, no enable), write precharge (cycles 6-7, precharge enable), write pulse (cycles 8-10).
- R4: The comparator flag counts only in read-pulse cycles whose index within the pulse is at least SENSE_DELAY (default 1, so only the second and third pulse cycles count). Any counted trip makes the sensed bit 1; otherwise it is 0.
- R5: Data out takes the sensed bit at the edge that ends the latch cycle, so it is valid from busy cycle 6. It holds that value until the latch of the next access.
- R6: On a read (write select = 0) the write pulse restores the sensed bit: the drive-to-1 enable for a 1, the drive-to-0 enable for a 0.
- R7: On a write (write select = 1) the write pulse polarity follows the data-in value captured when the access was sampled.
- R8: An access request while busy is ignored: the running sequence keeps its timing and no new cycle starts after it ends.
- R9: Enables are driven only for the unit whose select bit was set when the access was sampled. Changes to select, write select or data in during the cycle have no effect.
- R10: If the select lines are not exactly one-hot when the access is sampled, the cycle runs with normal busy and data-out timing, but every enable stays low.
- R11: The drive-to-0 and drive-to-1 enables are never high together. No precharge enable is high in the same cycle as a drive enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| access_i | input | 1 | Access request, sampled while idle |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| din_i | input | 1 | Data bit for a write access |
| sel_i | input | 7 | One line per storage unit, must be one-hot |
| sense_trip_i | input | 1 | Comparator trip flag from the sense path |
| busy_o | output | 1 | High while a cycle is in progress |
| dout_o | output | 1 | Latched sensed bit |
| pre_en_o | output | 7 | Per-unit precharge enable |
| drv0_en_o | output | 7 | Per-unit drive toward 0 (read pulse and write-0 pulse) |
| drv1_en_o | output | 7 | Per-unit drive toward 1 (write-1 pulse) |

## Verification
Two things can happen at the same edge: the last counted comparator sample of the read pulse, and a stray access request arriving while the block is busy. The bench raises access with an inverted write select on exactly the edge that ends the read pulse, with the comparator tripping there. It then checks that data out still takes the sensed bit and that the enables and busy keep their normal per-cycle pattern. It also checks that no second cycle starts after busy falls. Separately, a comparator trip placed only in the first pulse cycle must be read as 0, which probes the edge of the sense window.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;
    localparam int CNT_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_PRE,
        PH_RD_PULSE,
        PH_LATCH,
        PH_WR_PRE,
        PH_WR_PULSE
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic               busy;
        logic               wr;
        logic               din;
        logic               unit_ok;
        logic               trip;
        logic               wbit;
        logic               dout;
    } ctrl_state_t;
endpackage

// File: rtl/core_sel_check.sv
module core_sel_check #(
    parameter int N_UNITS = 7
) (
    input  logic [N_UNITS-1:0] sel_i,
    output logic               one_hot_o
);
    localparam int SUM_W = $clog2(N_UNITS + 1);

    logic [SUM_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < N_UNITS; i++) begin
            ones = ones + SUM_W'(sel_i[i]);
        end
        one_hot_o = (ones == SUM_W'(1));
    end
endmodule

// File: rtl/core_phase_ctrl.sv
module core_phase_ctrl
    import core_seq_pkg::*;
#(
    parameter int N_UNITS      = 7,
    parameter int RD_PRE_LEN   = 2,
    parameter int RD_PULSE_LEN = 3,
    parameter int LATCH_LEN    = 1,
    parameter int WR_PRE_LEN   = 2,
    parameter int WR_PULSE_LEN = 3,
    parameter int SENSE_DELAY  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               access_i,
    input  logic               wr_i,
    input  logic               din_i,
    input  logic [N_UNITS-1:0] sel_i,
    input  logic               sel_ok_i,
    input  logic               sense_trip_i,
    output phase_e             phase_o,
    output logic               busy_o,
    output logic               dout_o,
    output logic               wbit_o,
    output logic               unit_ok_o,
    output logic [N_UNITS-1:0] sel_o
);
    ctrl_state_t        s_d, s_q;
    logic [N_UNITS-1:0] sel_d, sel_q;
    logic [CNT_W-1:0]   last_cnt;
    logic               at_last;

    function automatic logic [CNT_W-1:0] last_of(input phase_e ph);
        case (ph)
            PH_RD_PRE:   return CNT_W'(RD_PRE_LEN - 1);
            PH_RD_PULSE: return CNT_W'(RD_PULSE_LEN - 1);
            PH_LATCH:    return CNT_W'(LATCH_LEN - 1);
            PH_WR_PRE:   return CNT_W'(WR_PRE_LEN - 1);
            PH_WR_PULSE: return CNT_W'(WR_PULSE_LEN - 1);
            default:     return '0;
        endcase
    endfunction

    function automatic phase_e next_of(input phase_e ph);
        case (ph)
            PH_RD_PRE:   return PH_RD_PULSE;
            PH_RD_PULSE: return PH_LATCH;
            PH_LATCH:    return PH_WR_PRE;
            PH_WR_PRE:   return PH_WR_PULSE;
            default:     return PH_IDLE;
        endcase
    endfunction

    always_comb begin
        s_d      = s_q;
        sel_d    = sel_q;
        last_cnt = last_of(s_q.phase);
        at_last  = (s_q.cnt == last_cnt);

        if (s_q.phase == PH_IDLE) begin
            if (access_i) begin
                s_d.phase   = PH_RD_PRE;
                s_d.cnt     = '0;
                s_d.busy    = 1'b1;
                s_d.wr      = wr_i;
                s_d.din     = din_i;
                s_d.unit_ok = sel_ok_i;
                s_d.trip    = 1'b0;
                sel_d       = sel_i;
            end
        end else begin
            if (at_last) begin
                s_d.phase = next_of(s_q.phase);
                s_d.cnt   = '0;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end

            if (s_q.phase == PH_RD_PULSE && sense_trip_i &&
                int'(s_q.cnt) >= SENSE_DELAY) begin
                s_d.trip = 1'b1;
            end

            if (s_q.phase == PH_LATCH && at_last) begin
                s_d.dout = s_q.trip;
                s_d.wbit = s_q.wr ? s_q.din : s_q.trip;
            end

            if (s_q.phase == PH_WR_PULSE && at_last) begin
                s_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q   <= '{phase: PH_IDLE, cnt: '0, busy: 1'b0, wr: 1'b0,
                       din: 1'b0, unit_ok: 1'b0, trip: 1'b0, wbit: 1'b0,
                       dout: 1'b0};
            sel_q <= '0;
        end else begin
            s_q   <= s_d;
            sel_q <= sel_d;
        end
    end

    assign phase_o   = s_q.phase;
    assign busy_o    = s_q.busy;
    assign dout_o    = s_q.dout;
    assign wbit_o    = s_q.wbit;
    assign unit_ok_o = s_q.unit_ok;
    assign sel_o     = sel_q;

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> $past(access_i));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.phase != PH_WR_PULSE) |=> s_q.busy);

    // R5
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_LATCH) |=> $stable(s_q.dout));
endmodule

// File: rtl/core_drive_decode.sv
module core_drive_decode
    import core_seq_pkg::*;
#(
    parameter int N_UNITS = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  phase_e             phase_i,
    input  logic               wbit_i,
    input  logic               unit_ok_i,
    input  logic [N_UNITS-1:0] sel_i,
    output logic [N_UNITS-1:0] pre_en_o,
    output logic [N_UNITS-1:0] drv0_en_o,
    output logic [N_UNITS-1:0] drv1_en_o
);
    logic in_pre, in_rd, in_wr;

    assign in_pre = (phase_i == PH_RD_PRE) || (phase_i == PH_WR_PRE);
    assign in_rd  = (phase_i == PH_RD_PULSE);
    assign in_wr  = (phase_i == PH_WR_PULSE);

    for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
        logic unit_en;
        assign unit_en      = unit_ok_i && sel_i[g];
        assign pre_en_o[g]  = unit_en && in_pre;
        assign drv0_en_o[g] = unit_en && (in_rd || (in_wr && !wbit_i));
        assign drv1_en_o[g] = unit_en && in_wr && wbit_i;
    end

    // R11
    polarity_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv0_en_o & drv1_en_o) == '0);

    // R11
    pre_pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en_o & (drv0_en_o | drv1_en_o)) == '0);

    // R9
    one_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pre_en_o | drv0_en_o | drv1_en_o));
endmodule

// File: rtl/core_access_seq.sv
module core_access_seq
    import core_seq_pkg::*;
#(
    parameter int N_UNITS      = 7,
    parameter int RD_PRE_LEN   = 2,
    parameter int RD_PULSE_LEN = 3,
    parameter int LATCH_LEN    = 1,
    parameter int WR_PRE_LEN   = 2,
    parameter int WR_PULSE_LEN = 3,
    parameter int SENSE_DELAY  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               access_i,
    input  logic               wr_i,
    input  logic               din_i,
    input  logic [N_UNITS-1:0] sel_i,
    input  logic               sense_trip_i,
    output logic               busy_o,
    output logic               dout_o,
    output logic [N_UNITS-1:0] pre_en_o,
    output logic [N_UNITS-1:0] drv0_en_o,
    output logic [N_UNITS-1:0] drv1_en_o
);
    logic               sel_ok;
    phase_e             phase;
    logic               wbit;
    logic               unit_ok;
    logic [N_UNITS-1:0] sel_held;

    core_sel_check #(.N_UNITS(N_UNITS)) u_sel_check (
        .sel_i     (sel_i),
        .one_hot_o (sel_ok)
    );

    core_phase_ctrl #(
        .N_UNITS      (N_UNITS),
        .RD_PRE_LEN   (RD_PRE_LEN),
        .RD_PULSE_LEN (RD_PULSE_LEN),
        .LATCH_LEN    (LATCH_LEN),
        .WR_PRE_LEN   (WR_PRE_LEN),
        .WR_PULSE_LEN (WR_PULSE_LEN),
        .SENSE_DELAY  (SENSE_DELAY)
    ) u_phase_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .access_i     (access_i),
        .wr_i         (wr_i),
        .din_i        (din_i),
        .sel_i        (sel_i),
        .sel_ok_i     (sel_ok),
        .sense_trip_i (sense_trip_i),
        .phase_o      (phase),
        .busy_o       (busy_o),
        .dout_o       (dout_o),
        .wbit_o       (wbit),
        .unit_ok_o    (unit_ok),
        .sel_o        (sel_held)
    );

    core_drive_decode #(.N_UNITS(N_UNITS)) u_drive_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_i   (phase),
        .wbit_i    (wbit),
        .unit_ok_i (unit_ok),
        .sel_i     (sel_held),
        .pre_en_o  (pre_en_o),
        .drv0_en_o (drv0_en_o),
        .drv1_en_o (drv1_en_o)
    );

    // R10
    bad_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && access_i && !$onehot(sel_i)) |=>
            ((pre_en_o | drv0_en_o | drv1_en_o) == '0));
endmodule

// File: tb/core_access_seq_tb.sv
module core_access_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       access_i = 1'b0;
    logic       wr_i = 1'b0;
    logic       din_i = 1'b0;
    logic [6:0] sel_i = '0;
    logic       sense_trip_i = 1'b0;
    logic       busy_o, dout_o;
    logic [6:0] pre_en_o, drv0_en_o, drv1_en_o;

    int checks = 0;
    int errors = 0;
    logic prev_dout = 1'b0;

    always #5 clk = ~clk;

    core_access_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .access_i     (access_i),
        .wr_i         (wr_i),
        .din_i        (din_i),
        .sel_i        (sel_i),
        .sense_trip_i (sense_trip_i),
        .busy_o       (busy_o),
        .dout_o       (dout_o),
        .pre_en_o     (pre_en_o),
        .drv0_en_o    (drv0_en_o),
        .drv1_en_o    (drv1_en_o)
    );

    // fields: [11] wr, [10] din, [9:8] trip mode, [7:1] select, [0] expected sensed bit
    // trip mode: 0 none, 1 whole read pulse, 2 first pulse cycle only
    localparam logic [11:0] VECS [8] = '{
        {1'b0, 1'b0, 2'd1, 7'b0000001, 1'b1},
        {1'b0, 1'b0, 2'd0, 7'b0000100, 1'b0},
        {1'b0, 1'b0, 2'd2, 7'b1000000, 1'b0},
        {1'b1, 1'b1, 2'd0, 7'b0010000, 1'b0},
        {1'b1, 1'b0, 2'd1, 7'b0000010, 1'b1},
        {1'b1, 1'b1, 2'd1, 7'b0000000, 1'b1},
        {1'b0, 1'b0, 2'd0, 7'b0000011, 1'b0},
        {1'b0, 1'b0, 2'd1, 7'b0001000, 1'b1}
    };

    task automatic check(input string tag, input logic [21:0] got,
                         input logic [21:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [21:0] exp_out(input int k, input logic ok,
                                            input logic [6:0] sel,
                                            input logic wbit);
        logic [6:0] m;
        logic b, p, d0, d1;
        m  = ok ? sel : 7'b0;
        b  = (k <= 10);
        p  = (k == 0 || k == 1 || k == 6 || k == 7);
        d0 = (k >= 2 && k <= 4) || (k >= 8 && k <= 10 && !wbit);
        d1 = (k >= 8 && k <= 10 && wbit);
        return {1'b0, b, p ? m : 7'b0, d0 ? m : 7'b0, d1 ? m : 7'b0};
    endfunction

    task automatic run_access(input logic wr, input logic din,
                              input logic [1:0] mode, input logic [6:0] sel,
                              input logic exp_bit, input bit inject);
        logic ok;
        logic wbit;
        string tag;
        ok   = ($countones(sel) == 1);
        wbit = wr ? din : exp_bit;
        @(negedge clk);
        access_i = 1'b1; wr_i = wr; din_i = din; sel_i = sel;
        sense_trip_i = 1'b0;
        for (int k = 0; k <= 12; k++) begin
            @(negedge clk);
            if (k == 0) begin
                access_i = 1'b0; sel_i = ~sel; wr_i = ~wr; din_i = ~din;
            end
            if (!ok)                    tag = "R10 bad select quiet";
            else if (inject && k >= 5)  tag = "R8 request while busy";
            else if (k <= 7)            tag = "R3 phase order / R9 unit";
            else if (k <= 10)           tag = wr ? "R7 write polarity" : "R6 restore polarity";
            else                        tag = "R2 busy length";
            check(tag, {1'b0, busy_o, pre_en_o, drv0_en_o, drv1_en_o},
                  exp_out(k, ok, sel, wbit));
            if (k == 5)
                check("R5 dout hold before latch", {21'b0, dout_o}, {21'b0, prev_dout});
            if (k == 6)
                check("R4 sensed bit on dout", {21'b0, dout_o}, {21'b0, exp_bit});
            if (inject && k == 4) begin access_i = 1'b1; wr_i = 1'b1; end
            if (inject && k == 5) access_i = 1'b0;
            case (mode)
                2'd1:    sense_trip_i = (k >= 2 && k <= 4);
                2'd2:    sense_trip_i = (k == 2);
                default: sense_trip_i = 1'b0;
            endcase
        end
        prev_dout = exp_bit;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", {1'b0, busy_o, pre_en_o, drv0_en_o, drv1_en_o, dout_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {1'b0, busy_o, pre_en_o, drv0_en_o, drv1_en_o, dout_o}, '0);

        for (int i = 0; i < 8; i++) begin
            run_access(VECS[i][11], VECS[i][10], VECS[i][9:8], VECS[i][7:1],
                       VECS[i][0], i == 7);
        end

        // R1: reset in the middle of a cycle, with dout holding 1
        @(negedge clk);
        access_i = 1'b1; wr_i = 1'b1; din_i = 1'b1; sel_i = 7'b0100000;
        @(negedge clk);
        access_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-cycle reset", {1'b0, busy_o, pre_en_o, drv0_en_o, drv1_en_o, dout_o}, '0);
        rst_n = 1'b1;
        prev_dout = 1'b0;
        @(negedge clk);
        check("R1 stays idle", {1'b0, busy_o, pre_en_o, drv0_en_o, drv1_en_o, dout_o}, '0);

        run_access(1'b0, 1'b1, 2'd1, 7'b0100000, 1'b1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule